// File: doc/BRIEF.md
# Colour Look-up Palette with Host Register Port

This block holds a colour look-up table of 256 entries. Each entry carries a 6-bit red, a 6-bit green and a 6-bit blue intensity, so the pixel path turns an 8-bit pixel index into an 18-bit colour. The pixel port is registered: the index presented in one cycle gives its colour after the next clock edge.

A host programs and inspects the table through a byte-wide register port. The port has a read strobe, a write strobe, a 2-bit offset and write data, and it returns read data combinationally in the strobe cycle. A write-index register and a read-index register each set the starting entry. A single data register then steps through the three colour components of that entry, red first, then green, then blue. After every third access the index advances by one, so the host can stream a run of consecutive entries. A state register reports whether the port was last set up for reading or for writing.

A written entry changes only when its blue component arrives. Red and green wait in staging registers until then, so the pixel path never shows a half-updated colour.

Top module: `palette_regs`

## Requirements
- R1: After reset every palette entry, both indices and the component position are zero, and the state register reads 0x00 (read mode).
- R2: A host write to offset 0 loads the write index, selects write mode and returns the component position to red; a host read of offset 0 returns the current write index.
- R3: A host write to offset 1 loads the read index, selects read mode and returns the component position to red.
- R4: Successive accesses to the data register at offset 2 cover red, green and blue in that order. The intensity sits in bits 5:0. Data reads return bits 7:6 as zero, and bits 7:6 of written data are ignored.
- R5: A palette entry changes only when the blue write of a triplet arrives, and it then takes the two staged components together with the blue value.
- R6: After the third data write of a triplet the write index increases by one, and it wraps from 255 to 0.
- R7: After the third data read of a triplet the read index increases by one, and it wraps from 255 to 0.
- R8: A host read of offset 1 returns the mode in bits 1:0, as 00 for read mode and 11 for write mode, with bits 7:2 zero.
- R9: The pixel port returns the colour of the entry at the presented index one clock edge later, packed as red in bits 17:12, green in bits 11:6 and blue in bits 5:0.
- R10: When a pixel look-up and a commit hit the same entry in the same cycle, the pixel output shows the old colour, and the next look-up of that entry shows the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe, one access per cycle held high |
| host_rd_i | input | 1 | Host read strobe, one access per cycle held high |
| host_addr_i | input | 2 | Register offset: 0 write index, 1 read index (write) or state (read), 2 data |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid in the cycle of the read strobe |
| pix_idx_i | input | 8 | Pixel index |
| pix_color_o | output | 18 | Colour of the indexed entry, one cycle later |

## Verification
The bench builds the block with its default parameters: an 8-bit index, 6-bit components and a byte-wide host port. With these values, loading index 255 directly puts both wrap-arounds within a single triplet. The same values bring the unused bits 7:6 of the data register within reach, as well as the full 18-bit packing on the pixel port.

// File: rtl/palette_pkg.sv
package palette_pkg;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;

  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_WRITE = 2'b11
  } mode_e;

  localparam logic [1:0] OFS_WR_IDX = 2'd0;
  localparam logic [1:0] OFS_RD_IDX = 2'd1;
  localparam logic [1:0] OFS_DATA   = 2'd2;

endpackage

// File: rtl/palette_seq.sv
module palette_seq
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_wr_idx_i,
  input  logic             ld_rd_idx_i,
  input  logic [IDX_W-1:0] idx_val_i,
  input  logic             data_wr_i,
  input  logic             data_rd_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output comp_e            comp_o,
  output mode_e            mode_o,
  output logic             commit_o
);

  comp_e            comp_q;
  mode_e            mode_q;
  logic [IDX_W-1:0] wr_idx_q, rd_idx_q;
  logic             last_comp;
  logic             data_acc;

  assign last_comp = (comp_q == COMP_BLU);
  assign data_acc  = data_wr_i | data_rd_i;
  assign commit_o  = data_wr_i & last_comp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_q   <= COMP_RED;
      mode_q   <= MODE_READ;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
    end else begin
      if (ld_wr_idx_i) begin
        wr_idx_q <= idx_val_i;
        mode_q   <= MODE_WRITE;
        comp_q   <= COMP_RED;
      end else if (ld_rd_idx_i) begin
        rd_idx_q <= idx_val_i;
        mode_q   <= MODE_READ;
        comp_q   <= COMP_RED;
      end else if (data_acc) begin
        unique case (comp_q)
          COMP_RED: comp_q <= COMP_GRN;
          COMP_GRN: comp_q <= COMP_BLU;
          default:  comp_q <= COMP_RED;
        endcase
        // index steps only after the blue access; natural wrap at 2**IDX_W
        if (last_comp && data_wr_i) wr_idx_q <= wr_idx_q + 1'b1;
        if (last_comp && data_rd_i) rd_idx_q <= rd_idx_q + 1'b1;
      end
    end
  end

  assign wr_idx_o = wr_idx_q;
  assign rd_idx_o = rd_idx_q;
  assign comp_o   = comp_q;
  assign mode_o   = mode_q;

  a_r4_comp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_q inside {COMP_RED, COMP_GRN, COMP_BLU});

  a_r2_wr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_wr_idx_i |=> (comp_q == COMP_RED) && (mode_q == MODE_WRITE));

  a_r3_rd_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_rd_idx_i && !ld_wr_idx_i) |=> (comp_q == COMP_RED) && (mode_q == MODE_READ));

  a_r6_wr_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && !ld_wr_idx_i && !ld_rd_idx_i) |=> wr_idx_q == $past(wr_idx_q) + 1'b1);

  a_r7_rd_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && last_comp && !ld_wr_idx_i && !ld_rd_idx_i)
      |=> rd_idx_q == $past(rd_idx_q) + 1'b1);

endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stage_en_i,
  input  comp_e               comp_i,
  input  logic                commit_i,
  input  logic [COMP_W-1:0]   wdata_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [COMP_W-1:0]   host_comp_o,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic [3*COMP_W-1:0] pix_color_o
);

  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned COL_W = 3 * COMP_W;

  logic [COL_W-1:0]  mem_q [DEPTH];
  logic [COMP_W-1:0] red_q, grn_q;
  logic [COL_W-1:0]  host_entry;
  logic [COL_W-1:0]  pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      red_q <= '0;
      grn_q <= '0;
    end else if (stage_en_i) begin
      if (comp_i == COMP_RED) red_q <= wdata_i;
      if (comp_i == COMP_GRN) grn_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      mem_q[wr_idx_i] <= {red_q, grn_q, wdata_i};
    end
  end

  // pixel read samples the pre-commit contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_q <= '0;
    else         pix_q <= mem_q[pix_idx_i];
  end

  assign host_entry = mem_q[rd_idx_i];

  always_comb begin
    unique case (comp_i)
      COMP_RED: host_comp_o = host_entry[3*COMP_W-1:2*COMP_W];
      COMP_GRN: host_comp_o = host_entry[2*COMP_W-1:COMP_W];
      default:  host_comp_o = host_entry[COMP_W-1:0];
    endcase
  end

  assign pix_color_o = pix_q;

  a_r5_commit_on_blue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> comp_i == COMP_BLU);

  a_r5_stage_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_en_i |=> $stable(red_q) && $stable(grn_q));

endmodule

// File: rtl/palette_regs.sv
module palette_regs
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_wr_i,
  input  logic                host_rd_i,
  input  logic [1:0]          host_addr_i,
  input  logic [DATA_W-1:0]   host_wdata_i,
  output logic [DATA_W-1:0]   host_rdata_o,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic [3*COMP_W-1:0] pix_color_o
);

  logic              ld_wr_idx, ld_rd_idx, data_wr, data_rd;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  comp_e             comp;
  mode_e             mode;
  logic              commit;
  logic [COMP_W-1:0] host_comp;

  assign ld_wr_idx = host_wr_i & (host_addr_i == OFS_WR_IDX);
  assign ld_rd_idx = host_wr_i & (host_addr_i == OFS_RD_IDX);
  assign data_wr   = host_wr_i & (host_addr_i == OFS_DATA);
  // a write on the same cycle wins the component step
  assign data_rd   = host_rd_i & ~host_wr_i & (host_addr_i == OFS_DATA);

  palette_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_wr_idx_i (ld_wr_idx),
    .ld_rd_idx_i (ld_rd_idx),
    .idx_val_i   (host_wdata_i[IDX_W-1:0]),
    .data_wr_i   (data_wr),
    .data_rd_i   (data_rd),
    .wr_idx_o    (wr_idx),
    .rd_idx_o    (rd_idx),
    .comp_o      (comp),
    .mode_o      (mode),
    .commit_o    (commit)
  );

  palette_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stage_en_i  (data_wr),
    .comp_i      (comp),
    .commit_i    (commit),
    .wdata_i     (host_wdata_i[COMP_W-1:0]),
    .wr_idx_i    (wr_idx),
    .rd_idx_i    (rd_idx),
    .host_comp_o (host_comp),
    .pix_idx_i   (pix_idx_i),
    .pix_color_o (pix_color_o)
  );

  always_comb begin
    host_rdata_o = '0;
    if (host_rd_i) begin
      unique case (host_addr_i)
        OFS_WR_IDX: host_rdata_o = DATA_W'(wr_idx);
        OFS_RD_IDX: host_rdata_o = DATA_W'(mode);
        OFS_DATA:   host_rdata_o = DATA_W'(host_comp);
        default:    host_rdata_o = '0;
      endcase
    end
  end

  a_r8_state_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_addr_i == OFS_RD_IDX) |-> host_rdata_o inside {DATA_W'(0), DATA_W'(3)});

  a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_addr_i == OFS_DATA) |-> host_rdata_o[DATA_W-1:COMP_W] == '0);

endmodule

// File: tb/tb_palette_regs.sv
module tb_palette_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_wr_i = 1'b0, host_rd_i = 1'b0;
  logic [1:0]  host_addr_i = '0;
  logic [7:0]  host_wdata_i = '0;
  logic [7:0]  host_rdata_o;
  logic [7:0]  pix_idx_i = '0;
  logic [17:0] pix_color_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_regs dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .pix_idx_i(pix_idx_i), .pix_color_o(pix_color_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr_i = 1'b1; host_addr_i = a; host_wdata_i = d;
    @(posedge clk); #1;
    host_wr_i = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd_i = 1'b1; host_addr_i = a;
    #1 d = host_rdata_o;
    @(posedge clk); #1;
    host_rd_i = 1'b0;
  endtask

  task automatic pix(input logic [7:0] idx, output logic [17:0] c);
    @(negedge clk);
    pix_idx_i = idx;
    @(posedge clk); #1;
    c = pix_color_o;
  endtask

  task automatic put_entry(input logic [7:0] idx, input logic [5:0] r, g, b);
    hwr(2'd0, idx);
    hwr(2'd2, {2'b00, r}); hwr(2'd2, {2'b00, g}); hwr(2'd2, {2'b00, b});
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [17:0] c;
    hrd(2'd1, d); check("R1 state after reset", d, 8'h00);
    hrd(2'd0, d); check("R1 write index after reset", d, 8'h00);
    pix(8'd77, c); check("R1 entry cleared", c, 18'h0);
    hrd(2'd2, d); check("R1 data read at index 0", d, 8'h00);
  endtask

  task automatic t_write_stream();
    logic [7:0] d; logic [17:0] c;
    hwr(2'd0, 8'd10);
    hrd(2'd1, d); check("R8 write mode code", d, 8'h03);
    hrd(2'd0, d); check("R2 write index readback", d, 8'd10);
    hwr(2'd2, 8'hC5);            // upper bits set, must be ignored
    hwr(2'd2, 8'h2A);
    pix(8'd10, c); check("R5 entry unchanged before blue", c, 18'h0);
    hwr(2'd2, 8'h13);
    pix(8'd10, c); check("R9 packed colour after commit", c, {6'h05, 6'h2A, 6'h13});
    hrd(2'd0, d); check("R6 write index stepped", d, 8'd11);
    hwr(2'd2, 8'h01); hwr(2'd2, 8'h02); hwr(2'd2, 8'h03);
    pix(8'd11, c); check("R6 streamed entry", c, {6'h01, 6'h02, 6'h03});
  endtask

  task automatic t_read_stream();
    logic [7:0] d;
    hwr(2'd1, 8'd10);
    hrd(2'd1, d); check("R3 read mode code", d, 8'h00);
    hrd(2'd2, d); check("R4 red first, upper zero", d, 8'h05);
    hrd(2'd2, d); check("R4 green second", d, 8'h2A);
    hrd(2'd2, d); check("R4 blue third", d, 8'h13);
    hrd(2'd2, d); check("R7 read index stepped", d, 8'h01);
    hwr(2'd1, 8'd11);            // reload mid-triplet returns to red
    hrd(2'd2, d); check("R3 component reset to red", d, 8'h01);
  endtask

  task automatic t_wrap();
    logic [7:0] d; logic [17:0] c;
    put_entry(8'd255, 6'h3F, 6'h00, 6'h21);
    hrd(2'd0, d); check("R6 write index wraps", d, 8'd0);
    hwr(2'd2, 8'h11); hwr(2'd2, 8'h12); hwr(2'd2, 8'h14);
    pix(8'd0, c); check("R6 entry 0 after wrap", c, {6'h11, 6'h12, 6'h14});
    hwr(2'd1, 8'd255);
    hrd(2'd2, d); hrd(2'd2, d); hrd(2'd2, d);
    check("R7 blue of entry 255", d, 8'h21);
    hrd(2'd2, d); check("R7 read index wraps to 0", d, 8'h11);
  endtask

  task automatic t_same_cycle();
    logic [17:0] c;
    hwr(2'd0, 8'd40);
    hwr(2'd2, 8'h0A); hwr(2'd2, 8'h0B);
    @(negedge clk);
    pix_idx_i = 8'd40; host_wr_i = 1'b1; host_addr_i = 2'd2; host_wdata_i = 8'h0C;
    @(posedge clk); #1;
    host_wr_i = 1'b0;
    c = pix_color_o; check("R10 old colour on commit cycle", c, 18'h0);
    pix(8'd40, c); check("R10 new colour next access", c, {6'h0A, 6'h0B, 6'h0C});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_write_stream();
    t_read_stream();
    t_wrap();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule